// File: doc/BRIEF.md
# Far-End Alarm Bit Generator

This block produces the two remote-indication bits carried in the maintenance byte of every outbound E3 frame: a far-end defect bit and a far-end block-error bit. The frame assembler around it supplies a start-of-frame strobe. On that strobe the block captures fresh values for both bits and holds them steady for the whole frame.

The bits come from one of two sources. In automatic mode they track the near-end receive framer. The defect bit reports whether loss of signal, alarm indication or loss of frame is present. The error bit reports whether the receiver flagged a BIP-8 error since the previous frame was sent. In manual mode software forces both bits through a maintenance byte. A small register write port sets the mode bit and that byte.

The three receive status levels may be asynchronous to the transmit clock, so each passes through a two-flop synchroniser. The BIP-8 error pulse, the write port and the frame strobe are synchronous to the clock.

Top module: `fe_alarm_gen`

## Requirements
- R1: In automatic mode, on a clock edge with frame_sof high, tx_far_defect loads 1 if any of the synchronised rx_los, rx_ais or rx_lof levels is high, and 0 if none is.
- R2: In automatic mode, on a clock edge with frame_sof high, tx_far_err loads 1 if an rx_bip_err pulse was seen on an edge after the previous frame_sof edge and before this one, and 0 otherwise.
- R3: In manual mode, on a clock edge with frame_sof high, tx_far_defect loads bit 7 and tx_far_err loads bit 6 of the maintenance byte. The maintenance byte is written at cfg_addr 0x11.
- R4: Bit 0 of a write to cfg_addr 0x10 sets the mode: 1 selects automatic and 0 selects manual. Writes to any other address leave both the mode and the maintenance byte unchanged.
- R5: tx_far_defect and tx_far_err change only on the edge at which frame_sof is high, and hold their values on every other edge.
- R6: The pending BIP-8 error is cleared by each frame_sof edge, in either mode. An rx_bip_err pulse on the same edge as frame_sof is counted toward the following frame.
- R7: After reset both outputs are 0, the mode is manual and the maintenance byte is 0x00.
- R8: Each of rx_los, rx_ais and rx_lof passes through two flops. A level first sampled on the edge just before a frame_sof edge is not seen by that frame_sof edge. A level first sampled two edges before it is seen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Transmit clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register write address |
| cfg_wdata | input | 8 | Register write data |
| rx_los | input | 1 | Receive loss of signal level, asynchronous |
| rx_ais | input | 1 | Receive alarm indication level, asynchronous |
| rx_lof | input | 1 | Receive loss of frame level, asynchronous |
| rx_bip_err | input | 1 | One-cycle BIP-8 error pulse from the receive framer |
| frame_sof | input | 1 | One-cycle start-of-frame strobe |
| tx_far_defect | output | 1 | Far-end defect bit for the current frame |
| tx_far_err | output | 1 | Far-end block-error bit for the current frame |

## Verification
The assertions assume that frame_sof, rx_bip_err and the write port are synchronous single-cycle events sampled on the rising edge. They check the outputs against the captured values one edge after the strobe. They make no assumption about the relative timing of the status levels, which only need to be settled for two edges before a strobe to count. The stimulus changes every input at the falling edge. The random phase changes status levels at arbitrary cycles, so strobes land both inside and outside the two-edge window. It also places BIP-8 pulses and writes on strobe cycles as well as between them.

// File: rtl/fe_alarm_pkg.sv
package fe_alarm_pkg;

  typedef enum logic {
    SRC_MANUAL = 1'b0,
    SRC_AUTO   = 1'b1
  } src_sel_e;

  typedef struct packed {
    logic defect;
    logic blk_err;
  } far_bits_t;

endpackage

// File: rtl/fe_status_sync.sv
module fe_status_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  localparam int unsigned LAST = STAGES - 1;

  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;

    always_comb begin
      chain_d = {chain_q[STAGES-2:0], async_in[g]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain_q <= '0;
      end else begin
        chain_q <= chain_d;
      end
    end

    assign sync_out[g] = chain_q[LAST];
  end

endmodule

// File: rtl/fe_cfg_regs.sv
module fe_cfg_regs
  import fe_alarm_pkg::*;
#(
  parameter int unsigned    ADDR_W     = 8,
  parameter int unsigned    DATA_W     = 8,
  parameter logic [ADDR_W-1:0] MODE_ADDR  = 8'h10,
  parameter logic [ADDR_W-1:0] MAINT_ADDR = 8'h11,
  parameter int unsigned    MODE_BIT   = 0,
  parameter int unsigned    DEFECT_BIT = 7,
  parameter int unsigned    ERR_BIT    = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output src_sel_e          mode,
  output far_bits_t         manual_bits
);

  logic              mode_wr;
  logic              maint_wr;
  src_sel_e          mode_q;
  src_sel_e          mode_d;
  logic [DATA_W-1:0] maint_q;
  logic [DATA_W-1:0] maint_d;

  always_comb begin
    mode_wr  = wr_en && (addr == MODE_ADDR);
    maint_wr = wr_en && (addr == MAINT_ADDR);
    mode_d   = mode_wr ? src_sel_e'(wdata[MODE_BIT]) : mode_q;
    maint_d  = maint_wr ? wdata : maint_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= SRC_MANUAL;
      maint_q <= '0;
    end else begin
      if (mode_wr) begin
        mode_q <= mode_d;
      end
      if (maint_wr) begin
        maint_q <= maint_d;
      end
    end
  end

  assign mode                = mode_q;
  assign manual_bits.defect  = maint_q[DEFECT_BIT];
  assign manual_bits.blk_err = maint_q[ERR_BIT];

  AST_MODE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == MODE_ADDR) |=> (mode == src_sel_e'($past(wdata[MODE_BIT])))); // R4

  AST_OTHER_ADDR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!(wr_en && (addr == MODE_ADDR || addr == MAINT_ADDR)))
      |=> ($stable(mode) && $stable(manual_bits))); // R4

endmodule

// File: rtl/fe_frame_latch.sv
module fe_frame_latch
  import fe_alarm_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      frame_sof,
  input  src_sel_e  mode,
  input  far_bits_t manual_bits,
  input  logic      status_any,
  input  logic      bip_err,
  output far_bits_t out_bits
);

  logic      pend_q;
  logic      pend_d;
  far_bits_t out_q;
  far_bits_t out_d;
  far_bits_t auto_bits;

  always_comb begin
    auto_bits.defect  = status_any;
    auto_bits.blk_err = pend_q;
    if (bip_err) begin
      pend_d = 1'b1;
    end else if (frame_sof) begin
      pend_d = 1'b0;
    end else begin
      pend_d = pend_q;
    end
    out_d = (mode == SRC_AUTO) ? auto_bits : manual_bits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      out_q  <= '0;
    end else begin
      pend_q <= pend_d;
      if (frame_sof) begin
        out_q <= out_d;
      end
    end
  end

  assign out_bits = out_q;

  AST_HOLD_BETWEEN_FRAMES: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_sof |=> $stable(out_bits)); // R5

  AST_AUTO_DEFECT: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_sof && mode == SRC_AUTO) |=> (out_bits.defect == $past(status_any))); // R1

  AST_AUTO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_sof && mode == SRC_AUTO) |=> (out_bits.blk_err == $past(pend_q))); // R2

  AST_MANUAL_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_sof && mode == SRC_MANUAL) |=> (out_bits == $past(manual_bits))); // R3

  AST_BIP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    bip_err |=> pend_q); // R6

  AST_BIP_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_sof && !bip_err) |=> !pend_q); // R6

endmodule

// File: rtl/fe_alarm_gen.sv
module fe_alarm_gen
  import fe_alarm_pkg::*;
#(
  parameter int unsigned    ADDR_W      = 8,
  parameter int unsigned    DATA_W      = 8,
  parameter logic [ADDR_W-1:0] MODE_ADDR   = 8'h10,
  parameter logic [ADDR_W-1:0] MAINT_ADDR  = 8'h11,
  parameter int unsigned    SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              rx_los,
  input  logic              rx_ais,
  input  logic              rx_lof,
  input  logic              rx_bip_err,
  input  logic              frame_sof,
  output logic              tx_far_defect,
  output logic              tx_far_err
);

  localparam int unsigned NUM_STATUS = 3;

  logic [NUM_STATUS-1:0] status_raw;
  logic [NUM_STATUS-1:0] status_sync;
  logic                  status_any;
  src_sel_e              mode;
  far_bits_t             manual_bits;
  far_bits_t             out_bits;

  assign status_raw = {rx_lof, rx_ais, rx_los};
  assign status_any = |status_sync;

  fe_status_sync #(
    .WIDTH  (NUM_STATUS),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (status_raw),
    .sync_out (status_sync)
  );

  fe_cfg_regs #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .MODE_ADDR  (MODE_ADDR),
    .MAINT_ADDR (MAINT_ADDR)
  ) u_cfg (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (cfg_wr_en),
    .addr        (cfg_addr),
    .wdata       (cfg_wdata),
    .mode        (mode),
    .manual_bits (manual_bits)
  );

  fe_frame_latch u_latch (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_sof   (frame_sof),
    .mode        (mode),
    .manual_bits (manual_bits),
    .status_any  (status_any),
    .bip_err     (rx_bip_err),
    .out_bits    (out_bits)
  );

  assign tx_far_defect = out_bits.defect;
  assign tx_far_err    = out_bits.blk_err;

endmodule

// File: tb/fe_alarm_gen_bench.sv
`timescale 1ns/1ps
module fe_alarm_gen_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_wr_en;
  logic [7:0] cfg_addr;
  logic [7:0] cfg_wdata;
  logic       rx_los, rx_ais, rx_lof, rx_bip_err, frame_sof;
  logic       tx_far_defect, tx_far_err;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic       m_mode, m_s1, m_s2, m_pend, m_def, m_err;
  logic [7:0] m_maint;

  always #2 clk = ~clk;

  fe_alarm_gen u_fe_alarm_gen (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_wr_en     (cfg_wr_en),
    .cfg_addr      (cfg_addr),
    .cfg_wdata     (cfg_wdata),
    .rx_los        (rx_los),
    .rx_ais        (rx_ais),
    .rx_lof        (rx_lof),
    .rx_bip_err    (rx_bip_err),
    .frame_sof     (frame_sof),
    .tx_far_defect (tx_far_defect),
    .tx_far_err    (tx_far_err)
  );

  function automatic logic exp_defect(logic mode, logic synced, logic [7:0] maint);
    return mode ? synced : maint[7];
  endfunction

  function automatic logic exp_err(logic mode, logic pend, logic [7:0] maint);
    return mode ? pend : maint[6];
  endfunction

  task automatic check(input string tag, input logic d, input logic e);
    checks++;
    if ({tx_far_defect, tx_far_err} !== {d, e}) begin
      fails++;
      $display("FAIL %s defect/err actual=%b%b expected=%b%b at %0t",
               tag, tx_far_defect, tx_far_err, d, e, $time);
    end
  endtask

  task automatic idle_inputs();
    cfg_wr_en  = 1'b0;
    cfg_addr   = 8'h00;
    cfg_wdata  = 8'h00;
    rx_bip_err = 1'b0;
    frame_sof  = 1'b0;
  endtask

  // Model one rising edge from the requirements, then compare at the falling edge.
  task automatic cyc(input string tag);
    logic n_s1, n_s2, n_pend, n_def, n_err, n_mode;
    logic [7:0] n_maint;
    n_s1  = rx_los | rx_ais | rx_lof;
    n_s2  = m_s1;
    n_def = m_def;
    n_err = m_err;
    if (frame_sof) begin
      n_def = exp_defect(m_mode, m_s2, m_maint);
      n_err = exp_err(m_mode, m_pend, m_maint);
    end
    n_pend  = rx_bip_err ? 1'b1 : (frame_sof ? 1'b0 : m_pend);
    n_mode  = m_mode;
    n_maint = m_maint;
    if (cfg_wr_en && cfg_addr == 8'h10) n_mode  = cfg_wdata[0];
    if (cfg_wr_en && cfg_addr == 8'h11) n_maint = cfg_wdata;
    @(posedge clk);
    m_s1 = n_s1; m_s2 = n_s2; m_pend = n_pend;
    m_def = n_def; m_err = n_err; m_mode = n_mode; m_maint = n_maint;
    @(negedge clk);
    check(tag, m_def, m_err);
    idle_inputs();
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d, input string tag);
    cfg_wr_en = 1'b1; cfg_addr = a; cfg_wdata = d;
    cyc(tag);
  endtask

  task automatic sof(input string tag);
    frame_sof = 1'b1;
    cyc(tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7250));
    rst_n = 1'b0;
    idle_inputs();
    rx_los = 1'b0; rx_ais = 1'b0; rx_lof = 1'b0;
    m_mode = 1'b0; m_s1 = 1'b0; m_s2 = 1'b0; m_pend = 1'b0;
    m_def = 1'b0; m_err = 1'b0; m_maint = 8'h00;
    repeat (3) @(negedge clk);
    check("R7_reset", 1'b0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R7_after_release", 1'b0, 1'b0);
    sof("R7_reset_manual_zero");

    // R3 manual bits
    wr(8'h11, 8'h80, "R5");
    sof("R3_defect_only");
    wr(8'h11, 8'h40, "R5");
    sof("R3_err_only");
    wr(8'h11, 8'hC0, "R5");
    sof("R3_both");

    // R4 other addresses ignored, observed through the outputs
    wr(8'h12, 8'h00, "R4");
    wr(8'h13, 8'h01, "R4");
    wr(8'h00, 8'h01, "R4");
    sof("R4_maint_untouched");
    wr(8'h11, 8'h00, "R5");
    rx_los = 1'b1;
    cyc("R5"); cyc("R5");
    sof("R4_mode_still_manual");
    rx_los = 1'b0;
    cyc("R5"); cyc("R5");

    // R4 select automatic, then R1 per status input
    wr(8'h10, 8'h01, "R4");
    sof("R1_none");
    rx_ais = 1'b1; cyc("R5"); cyc("R5");
    sof("R1_ais");
    rx_ais = 1'b0; rx_lof = 1'b1; cyc("R5"); cyc("R5");
    sof("R1_lof");
    rx_lof = 1'b0; cyc("R5"); cyc("R5");
    sof("R1_cleared");

    // R8 synchroniser latency
    rx_los = 1'b1; cyc("R5");
    sof("R8_one_edge_not_seen");
    sof("R8_two_edges_seen");
    rx_los = 1'b0; cyc("R5"); cyc("R5");
    sof("R1_los_cleared");

    // R2 and R6 BIP-8 handling
    rx_bip_err = 1'b1; cyc("R5");
    sof("R2_err_reported");
    sof("R6_err_cleared");
    rx_bip_err = 1'b1; frame_sof = 1'b1;
    cyc("R6_same_edge_not_this_frame");
    sof("R6_same_edge_next_frame");
    wr(8'h10, 8'h00, "R4");
    rx_bip_err = 1'b1; cyc("R5");
    sof("R6_manual_clears_pending");
    wr(8'h10, 8'h01, "R4");
    sof("R6_no_stale_error");

    // Random phase
    for (int i = 0; i < 4000; i++) begin
      string tag;
      if (($urandom % 16) == 0) rx_los = ~rx_los;
      if (($urandom % 16) == 0) rx_ais = ~rx_ais;
      if (($urandom % 16) == 0) rx_lof = ~rx_lof;
      rx_bip_err = (($urandom % 8) == 0);
      frame_sof  = (($urandom % 6) == 0);
      if (($urandom % 10) == 0) begin
        cfg_wr_en = 1'b1;
        case ($urandom % 3)
          0: cfg_addr = 8'h10;
          1: cfg_addr = 8'h11;
          default: cfg_addr = 8'($urandom);
        endcase
        cfg_wdata = 8'($urandom);
      end
      if (frame_sof) tag = m_mode ? "R1 R2 random" : "R3 random";
      else           tag = "R5 random";
      cyc(tag);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule